// File: doc/BRIEF.md
# Shared Timer Prescaler with Synchronised Start

This block divides the system clock for two timer/counters that share a single prescaler. A 10-bit free-running counter produces one-cycle enable ticks at the clock divided by 1, 8, 64, 256 and 1024. Each timer picks one of these taps with its own 3-bit select input. The timer counters are outside this block and advance only on their tick.

One control byte on a simple register bus governs the prescaler. A hold bit freezes both timers by forcing every tick low and raising a halt output. A synchronous reset bit clears the shared counter. While the hold bit is set, that reset bit stays set, so the counter is held at zero. Software sets hold and reset together, configures both timers, and then writes zero to the hold bit. That write clears both reset bits, and the two timers start from the same counter phase on the same cycle. A second reset bit, kept for an asynchronous timer, is a plain register bit with the same set and clear rules. It has no effect on the shared counter.

Top module: `tmr_prescale_ctl`

## Requirements
- R1: After reset, the control byte reads 0x00, the halt output is low, and the prescaler counter is zero.
- R2: The control byte sits at bus address 0x43. A read returns hold in bit 7, the asynchronous reset bit in bit 1, the synchronous reset bit in bit 0, and zero in bits 6..2. The read data is 0x00 when the read strobe is low or the address differs. A write to any other address changes nothing.
- R3: While the hold bit is 1, the halt output is 1 and both tick outputs are 0, whatever the selects are.
- R4: Writing 1 to bit 0 while the hold bit is 1 holds the prescaler counter at zero, and bit 0 keeps reading 1 for as long as the hold bit stays 1.
- R5: A write with bit 7 equal to 0 clears bits 1 and 0 at the same clock edge, unless that same write sets them. The halt output falls at that edge.
- R6: With the hold bit at 0, a set bit 0 reads 1 for exactly one cycle. On the next edge the counter returns to zero and the bit clears.
- R7: Bit 1 follows the same set, hold and clear rules as bit 0, but never alters the prescaler counter.
- R8: The counter advances by one every cycle unless it is being reset. Select value s from 1 to 5 chooses the divisor 1, 8, 64, 256 or 1024. The tick for divisor D is high exactly in the cycles where the counter's low log2(D) bits are all ones, so ticks are D cycles apart.
- R9: Select values 0, 6 and 7 produce no ticks.
- R10: After a synchronised release, a timer with divisor D gives its first tick D-1 cycles after the release edge. Two timers with equal selects tick on identical cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| tmr0_sel | input | 3 | Tap select for timer 0 (0 = stopped) |
| tmr1_sel | input | 3 | Tap select for timer 1 (0 = stopped) |
| tmr0_tick | output | 1 | Count enable for timer 0 |
| tmr1_tick | output | 1 | Count enable for timer 1 |
| halt | output | 1 | High while the timers are frozen |

## Verification
The hardest state to reach from the ports is a known counter phase, because the counter runs freely and cannot be read. Each scenario therefore begins with a synchronised restart: one write sets hold and reset together, and a second write clears hold. This puts the counter at zero on a known edge, and every later tick position is counted from that edge. The single-cycle visibility of a self-clearing reset bit is caught by reading in the cycle right after the write and again one cycle later.

// File: rtl/pscl_pkg.sv
package pscl_pkg;

    localparam int CNT_W    = 10;
    localparam int NUM_TAPS = 5;
    localparam int SEL_W    = 3;
    localparam int BUS_W    = 8;

    // Power-of-two exponent of each tap divisor: /1, /8, /64, /256, /1024
    function automatic int tap_shift(input int idx);
        case (idx)
            0:       return 0;
            1:       return 3;
            2:       return 6;
            3:       return 8;
            default: return 10;
        endcase
    endfunction

    typedef struct packed {
        logic hold;
        logic rst_async;
        logic rst_sync;
    } ctl_t;

endpackage

// File: rtl/pscl_ctl_reg.sv
module pscl_ctl_reg
    import pscl_pkg::*;
#(
    parameter int          BW        = BUS_W,
    parameter logic [7:0]  REG_ADDR  = 8'h43,
    parameter int          HOLD_BIT  = 7,
    parameter int          ASYNC_BIT = 1,
    parameter int          SYNC_BIT  = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic          rd,
    input  logic [7:0]    addr,
    input  logic [BW-1:0] wdata,
    output logic [BW-1:0] rdata,
    output ctl_t          ctl
);

    ctl_t regs_d, regs_q;
    logic hit_wr;
    logic unused_wbits;

    localparam logic [BW-1:0] USED_MASK =
        (BW'(1) << HOLD_BIT) | (BW'(1) << ASYNC_BIT) | (BW'(1) << SYNC_BIT);

    assign hit_wr       = wr && (addr == REG_ADDR);
    assign unused_wbits = ^(wdata & ~USED_MASK);

    // Next-state: set by writing 1, cleared when hold is released or
    // (when hold is low) one cycle after the bit was set.
    always_comb begin
        regs_d = regs_q;
        if (hit_wr) regs_d.hold = wdata[HOLD_BIT];

        if (hit_wr && wdata[SYNC_BIT])
            regs_d.rst_sync = 1'b1;
        else if (hit_wr && !wdata[HOLD_BIT])
            regs_d.rst_sync = 1'b0;
        else if (!regs_q.hold && regs_q.rst_sync)
            regs_d.rst_sync = 1'b0;

        if (hit_wr && wdata[ASYNC_BIT])
            regs_d.rst_async = 1'b1;
        else if (hit_wr && !wdata[HOLD_BIT])
            regs_d.rst_async = 1'b0;
        else if (!regs_q.hold && regs_q.rst_async)
            regs_d.rst_async = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        rdata = '0;
        if (rd && addr == REG_ADDR) begin
            rdata[HOLD_BIT]  = regs_q.hold;
            rdata[ASYNC_BIT] = regs_q.rst_async;
            rdata[SYNC_BIT]  = regs_q.rst_sync;
        end
    end

    assign ctl = regs_q;

    assert_keep_while_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.hold && regs_q.rst_sync && !hit_wr) |=> regs_q.rst_sync);

    assert_release_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_wr && !wdata[HOLD_BIT] && !wdata[SYNC_BIT] && !wdata[ASYNC_BIT])
        |=> (!regs_q.hold && !regs_q.rst_sync && !regs_q.rst_async));

    assert_self_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!regs_q.hold && regs_q.rst_sync && !(hit_wr && wdata[SYNC_BIT]))
        |=> !regs_q.rst_sync);

    assert_async_self_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!regs_q.hold && regs_q.rst_async && !(hit_wr && wdata[ASYNC_BIT]))
        |=> !regs_q.rst_async);

    assert_foreign_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit_wr && !regs_q.rst_sync && !regs_q.rst_async)
        |=> $stable(regs_q.hold));

endmodule

// File: rtl/pscl_counter.sv
module pscl_counter
    import pscl_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int NT = NUM_TAPS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rst_req,
    output logic [NT-1:0] tap_en
);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst_req) st_d.cnt = '0;
        else         st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar g = 0; g < NT; g++) begin : g_tap
        localparam int SH = (tap_shift(g) > CW) ? CW : tap_shift(g);
        if (SH == 0) begin : g_full
            assign tap_en[g] = 1'b1;
        end else begin : g_div
            assign tap_en[g] = &st_q.cnt[SH-1:0];
        end
    end

    assert_reset_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> (st_q.cnt == '0));

    assert_count_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_req |=> (st_q.cnt == CW'($past(st_q.cnt) + 1'b1)));

endmodule

// File: rtl/pscl_tap_sel.sv
module pscl_tap_sel
    import pscl_pkg::*;
#(
    parameter int NT = NUM_TAPS,
    parameter int SW = SEL_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          halt,
    input  logic [SW-1:0] sel,
    input  logic [NT-1:0] tap_en,
    output logic          tick
);

    always_comb begin
        tick = 1'b0;
        for (int i = 0; i < NT; i++) begin
            if (sel == SW'(i + 1)) tick = tap_en[i];
        end
        if (halt) tick = 1'b0;
    end

    assert_halt_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        halt |-> !tick);

    assert_stop_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((sel == '0) || (int'(sel) > NT)) |-> !tick);

endmodule

// File: rtl/tmr_prescale_ctl.sv
module tmr_prescale_ctl
    import pscl_pkg::*;
#(
    parameter int         CW       = CNT_W,
    parameter int         NT       = NUM_TAPS,
    parameter int         SW       = SEL_W,
    parameter logic [7:0] REG_ADDR = 8'h43
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [7:0]    bus_addr,
    input  logic [7:0]    bus_wdata,
    output logic [7:0]    bus_rdata,
    input  logic [SW-1:0] tmr0_sel,
    input  logic [SW-1:0] tmr1_sel,
    output logic          tmr0_tick,
    output logic          tmr1_tick,
    output logic          halt
);

    localparam int NUM_TMR = 2;

    ctl_t                      ctl;
    logic [NT-1:0]             tap_en;
    logic [NUM_TMR-1:0][SW-1:0] sel_all;
    logic [NUM_TMR-1:0]        tick_all;

    pscl_ctl_reg #(.BW(8), .REG_ADDR(REG_ADDR)) u_ctl (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (bus_wr),
        .rd    (bus_rd),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .rdata (bus_rdata),
        .ctl   (ctl)
    );

    pscl_counter #(.CW(CW), .NT(NT)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .rst_req (ctl.rst_sync),
        .tap_en  (tap_en)
    );

    assign sel_all[0] = tmr0_sel;
    assign sel_all[1] = tmr1_sel;

    for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
        pscl_tap_sel #(.NT(NT), .SW(SW)) u_sel (
            .clk    (clk),
            .rst_n  (rst_n),
            .halt   (ctl.hold),
            .sel    (sel_all[t]),
            .tap_en (tap_en),
            .tick   (tick_all[t])
        );
    end

    assign tmr0_tick = tick_all[0];
    assign tmr1_tick = tick_all[1];
    assign halt      = ctl.hold;

    assert_same_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr0_sel == tmr1_sel) |-> (tmr0_tick == tmr1_tick));

endmodule

// File: tb/tmr_prescale_ctl_test.sv
module tmr_prescale_ctl_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_addr = 8'h00, bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [2:0] tmr0_sel = 3'd0, tmr1_sel = 3'd0;
    logic       tmr0_tick, tmr1_tick, halt;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;

    localparam logic [7:0] CTL = 8'h43;

    tmr_prescale_ctl uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tmr0_sel(tmr0_sel), .tmr1_sel(tmr1_sel),
        .tmr0_tick(tmr0_tick), .tmr1_tick(tmr1_tick), .halt(halt)
    );

    always #10 clk = ~clk;   // 50 MHz

    always @(posedge clk) begin
        cycles++;
        if (cycles >= 200000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: act=%0d cycles exp<200000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk); #1;
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        step();
        bus_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [7:0] a, output logic [7:0] v);
        bus_rd = 1'b1; bus_addr = a;
        #1 v = bus_rdata;
        bus_rd = 1'b0;
    endtask

    // Leaves the counter at zero in the current cycle
    task automatic sync_restart();
        wr_reg(CTL, 8'h81);
        wr_reg(CTL, 8'h00);
    endtask

    function automatic int div_of(input int s);
        case (s)
            1: return 1; 2: return 8; 3: return 64; 4: return 256;
            default: return 1024;
        endcase
    endfunction

    task automatic t_reset();
        logic [7:0] v;
        rd_reg(CTL, v);
        check(v == 8'h00, "R1 reset readback", v, 0);
        check(halt == 1'b0, "R1 halt after reset", halt, 0);
        tmr0_sel = 3'd1;
        #1 check(tmr0_tick == 1'b1, "R1 div1 tick after reset", tmr0_tick, 1);
        tmr0_sel = 3'd0;
    endtask

    task automatic t_addr();
        logic [7:0] v;
        wr_reg(8'h42, 8'h81);
        check(halt == 1'b0, "R2 foreign write ignored", halt, 0);
        rd_reg(CTL, v);
        check(v == 8'h00, "R2 foreign write readback", v, 0);
        wr_reg(CTL, 8'h80);
        rd_reg(CTL, v);
        check(v == 8'h80, "R2 hold bit readback", v, 8'h80);
        rd_reg(8'h44, v);
        check(v == 8'h00, "R2 other address reads zero", v, 0);
        #1 check(bus_rdata == 8'h00, "R2 no strobe reads zero", bus_rdata, 0);
        wr_reg(CTL, 8'h00);
    endtask

    task automatic t_halt();
        int seen = 0;
        wr_reg(CTL, 8'h80);
        check(halt == 1'b1, "R3 halt raised", halt, 1);
        for (int s = 1; s <= 5; s++) begin
            tmr0_sel = 3'(s); tmr1_sel = 3'(s);
            for (int k = 0; k < 40; k++) begin
                if (tmr0_tick || tmr1_tick) seen++;
                step();
            end
        end
        check(seen == 0, "R3 ticks gated while halted", seen, 0);
        wr_reg(CTL, 8'h00);
        check(halt == 1'b0, "R5 halt drops on release", halt, 0);
    endtask

    task automatic t_sync_start();
        logic [7:0] v;
        int diff = 0, wrong = 0;
        wr_reg(CTL, 8'h81);
        rd_reg(CTL, v);
        check(v == 8'h81, "R4 hold+reset readback", v, 8'h81);
        repeat (5) step();
        rd_reg(CTL, v);
        check(v == 8'h81, "R4 reset stays while held", v, 8'h81);
        tmr0_sel = 3'd2; tmr1_sel = 3'd2;
        wr_reg(CTL, 8'h00);
        rd_reg(CTL, v);
        check(v == 8'h00, "R5 release clears reset bits", v, 0);
        for (int k = 0; k < 24; k++) begin
            if (tmr0_tick != tmr1_tick) diff++;
            if (tmr0_tick != ((k % 8) == 7)) wrong++;
            step();
        end
        check(diff == 0, "R10 equal selects tick together", diff, 0);
        check(wrong == 0, "R10 first tick at D-1 after release", wrong, 0);
    endtask

    task automatic t_spacing();
        for (int s = 1; s <= 5; s++) begin
            int d = div_of(s);
            int first = -1, n = 0, diff = 0;
            tmr0_sel = 3'(s); tmr1_sel = 3'(s);
            sync_restart();
            for (int k = 0; k < 2 * d; k++) begin
                if (tmr0_tick) begin
                    if (first < 0) first = k;
                    n++;
                end
                if (tmr0_tick != tmr1_tick) diff++;
                step();
            end
            check(first == d - 1, "R8 first tick position", first, d - 1);
            check(n == 2, "R8 ticks per 2D cycles", n, 2);
            check(diff == 0, "R10 both timers aligned", diff, 0);
        end
    endtask

    task automatic t_mixed();
        int first_b = -1;
        tmr0_sel = 3'd2; tmr1_sel = 3'd3;
        sync_restart();
        for (int k = 0; k < 64; k++) begin
            if (tmr1_tick && first_b < 0) first_b = k;
            step();
        end
        check(first_b == 63, "R10 /64 timer first tick after release", first_b, 63);
    endtask

    task automatic t_self_clear();
        logic [7:0] v;
        int wrong = 0;
        tmr0_sel = 3'd2; tmr1_sel = 3'd2;
        sync_restart();
        repeat (3) step();
        wr_reg(CTL, 8'h01);
        rd_reg(CTL, v);
        check(v == 8'h01, "R6 reset bit visible one cycle", v, 1);
        step();
        rd_reg(CTL, v);
        check(v == 8'h00, "R6 reset bit self-cleared", v, 0);
        for (int k = 0; k < 16; k++) begin
            if (tmr0_tick != ((k % 8) == 7)) wrong++;
            step();
        end
        check(wrong == 0, "R6 counter restarted from zero", wrong, 0);
    endtask

    task automatic t_async();
        logic [7:0] v;
        int wrong = 0;
        tmr0_sel = 3'd2;
        sync_restart();               // k = 0 here
        wr_reg(CTL, 8'h02);           // k = 1
        rd_reg(CTL, v);
        check(v == 8'h02, "R7 async bit visible", v, 2);
        step();                       // k = 2
        rd_reg(CTL, v);
        check(v == 8'h00, "R7 async bit self-cleared", v, 0);
        for (int k = 2; k < 16; k++) begin
            if (tmr0_tick != ((k % 8) == 7)) wrong++;
            step();
        end
        check(wrong == 0, "R7 async bit leaves counter alone", wrong, 0);
        wr_reg(CTL, 8'h82);
        repeat (3) step();
        rd_reg(CTL, v);
        check(v == 8'h82, "R7 async bit held while hold set", v, 8'h82);
        wr_reg(CTL, 8'h00);
        rd_reg(CTL, v);
        check(v == 8'h00, "R5 release clears async bit", v, 0);
    endtask

    task automatic t_stopped();
        int seen;
        for (int s = 0; s < 8; s++) begin
            if (s >= 1 && s <= 5) continue;
            seen = 0;
            tmr0_sel = 3'(s); tmr1_sel = 3'(s);
            sync_restart();
            for (int k = 0; k < 1100; k++) begin
                if (tmr0_tick || tmr1_tick) seen++;
                step();
            end
            check(seen == 0, "R9 no ticks for stop/unused select", seen, 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_addr();
        t_halt();
        t_sync_start();
        t_spacing();
        t_mixed();
        t_self_clear();
        t_async();
        t_stopped();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule